// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes the accumulator, a second operand, the current status byte and a 4-bit operation code. It returns the new accumulator value, a write strobe for the accumulator, and the new status byte. Every operation has its own rule for each flag: the flag is computed from the result, forced to a constant, or passed through from the incoming status byte.

The status byte holds sign, zero, half-carry, parity/overflow, subtract and carry at fixed bit positions. The parity/overflow bit carries signed overflow after arithmetic and even parity after logic operations and decimal adjust. The surrounding datapath fetches the operand, registers the status byte, and writes the accumulator when the strobe is high. The block holds no state.

Top module: `alu8_core`

## Requirements
- R1: Status byte layout: sign bit 7, zero bit 6, half-carry bit 4, parity/overflow bit 2, subtract bit 1, carry bit 0. Bits 5 and 3 of `flags_o` always equal bits 5 and 3 of `flags_i`.
- R2: `op_i` encoding: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP, 8 INC, 9 DEC, 10 NEG, 11 CPL, 12 DAA, 13 SCF, 14 CCF, 15 HOLD. HOLD gives `result_o` = `acc_i`, `flags_o` = `flags_i` and no write.
- R3: ADD adds A and the operand, and ADC also adds the incoming carry. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, parity/overflow is signed overflow, and subtract is 0.
- R4: SUB computes A minus the operand, and SBC also subtracts the incoming carry. NEG computes 0 minus A. Carry is the borrow out of bit 7, half-carry is the borrow into bit 4, parity/overflow is signed overflow, and subtract is 1.
- R5: CP sets the flags exactly as SUB would, does not write the accumulator, and drives `result_o` = `acc_i`.
- R6: AND, XOR and OR clear subtract and carry. Parity/overflow is 1 when the result has an even number of ones. Half-carry is 1 for AND and 0 for XOR and OR.
- R7: INC and DEC add or subtract 1 and keep the carry. Overflow is set only for 0x7F to 0x80 (INC) and for 0x80 to 0x7F (DEC). Subtract is 0 for INC and 1 for DEC. Half-carry follows R3 and R4.
- R8: CPL drives `result_o` = ~A and sets half-carry and subtract. Sign, zero, parity/overflow and carry pass through unchanged.
- R9: SCF sets carry and clears half-carry and subtract. CCF inverts carry, copies the old carry into half-carry, and clears subtract. Neither writes the accumulator, and neither changes sign, zero or parity/overflow.
- R10: DAA adds 0x06 when the low nibble is above 9 or half-carry is set. It adds 0x60 and sets carry when A is above 0x99 or carry is set. When subtract is set, it subtracts these amounts instead. Half-carry becomes (low nibble > 9) after an addition, and (half-carry AND low nibble < 6) after a subtraction. Parity/overflow is parity, and subtract passes through.
- R11: For every operation that produces a new value (codes 0–12), sign equals bit 7 of that value and zero is set when the value is 0. For CP the value is the difference.
- R12: `acc_we_o` is 1 for codes 0–6 and 8–12, and 0 for 7, 13, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current status byte |
| op_i | input | 4 | Operation code (R2) |
| result_o | output | 8 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | New status byte |

## Verification
The bench builds the block with its default data width of 8 and nibble width of 4. This is the only setting at which the decimal-adjust limits and the overflow corners 0x7F/0x80 have their intended meaning. At these values the bench can reach every carry, half-carry and overflow corner with directed operands: wrap to zero, signed boundary crossings, borrows into bit 4, and the two decimal-adjust corrections applied together. It drives the status inputs with set bits to show which flags each operation forces and which it passes through.

// File: rtl/alu8_pkg.sv
// Package: shared widths, status-bit positions and operation codes for the ALU.
// Assumes an 8-bit datapath split into two nibbles for half-carry and decimal adjust.
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PV   = 2;
    localparam int FB_SUB  = 1;
    localparam int FB_CARRY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_CP   = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_NEG  = 4'd10,
        OP_CPL  = 4'd11,
        OP_DAA  = 4'd12,
        OP_SCF  = 4'd13,
        OP_CCF  = 4'd14,
        OP_HOLD = 4'd15
    } alu_op_e;

    // Even parity: 1 when the number of set bits is even.
    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: a +/- b +/- cin with carry, half-carry and signed overflow.
// Assumes W is even; half-carry is taken at the nibble boundary W/2.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         co_o,
    output logic         hc_o,
    output logic         ov_o
);
    localparam int N = W / 2;

    logic [W:0] wide;
    logic [N:0] low;

    // Full-width and low-nibble sums or differences, with the bit above each as carry/borrow.
    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[N-1:0]} - {1'b0, b_i[N-1:0]} - {{N{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[N-1:0]} + {1'b0, b_i[N-1:0]} + {{N{1'b0}}, cin_i};
        end
    end

    assign res_o = wide[W-1:0];
    assign co_o  = wide[W];
    assign hc_o  = low[N];

    // Signed overflow: same-sign operands for add, opposite-sign for subtract, result sign flipped.
    always_comb begin
        if (sub_i)
            ov_o = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
        else
            ov_o = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, XOR or OR of two operands, with the half-carry value each forces.
// Assumes sel_i uses 0 = AND, 1 = XOR, 2 = OR; 3 behaves as OR.
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o,
    output logic         hc_o
);
    // Pick the bitwise function; only AND forces half-carry high.
    always_comb begin
        case (sel_i)
            2'd0:    begin res_o = a_i & b_i; hc_o = 1'b1; end
            2'd1:    begin res_o = a_i ^ b_i; hc_o = 1'b0; end
            default: begin res_o = a_i | b_i; hc_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
// Decimal adjust: corrects a binary add/subtract result back to two packed BCD digits.
// Assumes the flags passed in are those left by the preceding add or subtract.
module alu8_daa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         sub_i,
    input  logic         hc_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         co_o,
    output logic         hc_o
);
    localparam int N = W / 2;
    localparam logic [W-1:0] ADJ_LO  = W'(6);
    localparam logic [W-1:0] ADJ_HI  = W'(6) << N;
    localparam logic [W-1:0] LIM_ALL = (W'(9) << N) | W'(9);
    localparam logic [N-1:0] LIM_NIB = N'(9);
    localparam logic [N-1:0] SIX_NIB = N'(6);

    logic             lo_big;
    logic             hi_big;
    logic [W-1:0]     corr;

    // Decide which nibble corrections apply.
    always_comb begin
        lo_big = a_i[N-1:0] > LIM_NIB;
        hi_big = a_i > LIM_ALL;
        corr   = ((lo_big || hc_i) ? ADJ_LO : '0) | ((hi_big || c_i) ? ADJ_HI : '0);
    end

    // Apply the correction in the direction of the previous operation.
    always_comb begin
        res_o = sub_i ? (a_i - corr) : (a_i + corr);
        co_o  = c_i || hi_big;
        hc_o  = sub_i ? (hc_i && (a_i[N-1:0] < SIX_NIB)) : lo_big;
    end
endmodule

// File: rtl/alu8_core.sv
// ALU top: decodes the operation, steers operands to the arithmetic, logic and
// decimal-adjust units, and assembles the result, write strobe and status byte.
// Assumes flags_i is the live status byte; bits 5 and 3 are carried through untouched.
module alu8_core
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_we_o,
    output logic [DATA_W-1:0] flags_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic              c_in;
    logic              h_in;
    logic              n_in;
    assign c_in = flags_i[FB_CARRY];
    assign h_in = flags_i[FB_HALF];
    assign n_in = flags_i[FB_SUB];

    logic [DATA_W-1:0] as_a, as_b, as_res;
    logic              as_cin, as_sub, as_co, as_hc, as_ov;
    logic [DATA_W-1:0] lg_res;
    logic              lg_hc;
    logic [DATA_W-1:0] da_res;
    logic              da_co, da_hc;

    // Steer operands and carry-in to the adder/subtractor for each arithmetic code.
    always_comb begin
        as_a   = acc_i;
        as_b   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = c_in;
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = c_in; end
            OP_INC: as_b = DATA_W'(1);
            OP_DEC: begin as_b = DATA_W'(1); as_sub = 1'b1; end
            OP_NEG: begin as_a = '0; as_b = acc_i; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a_i  (as_a),
        .b_i  (as_b),
        .cin_i(as_cin),
        .sub_i(as_sub),
        .res_o(as_res),
        .co_o (as_co),
        .hc_o (as_hc),
        .ov_o (as_ov)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .sel_i(op_i[1:0]),
        .res_o(lg_res),
        .hc_o (lg_hc)
    );

    alu8_daa #(.W(DATA_W)) u_daa (
        .a_i  (acc_i),
        .sub_i(n_in),
        .hc_i (h_in),
        .c_i  (c_in),
        .res_o(da_res),
        .co_o (da_co),
        .hc_o (da_hc)
    );

    logic [DATA_W-1:0] val;  // value that drives sign and zero

    // Assemble result, write strobe and status byte per operation.
    always_comb begin
        result_o = acc_i;
        acc_we_o = 1'b0;
        flags_o  = flags_i;
        val      = acc_i;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CP: begin
                val               = as_res;
                flags_o[FB_HALF]  = as_hc;
                flags_o[FB_PV]    = as_ov;
                flags_o[FB_SUB]   = as_sub;
                flags_o[FB_CARRY] = as_co;
                if (op != OP_CP) begin
                    result_o = as_res;
                    acc_we_o = 1'b1;
                end
            end
            OP_INC, OP_DEC: begin
                val              = as_res;
                result_o         = as_res;
                acc_we_o         = 1'b1;
                flags_o[FB_HALF] = as_hc;
                flags_o[FB_PV]   = as_ov;
                flags_o[FB_SUB]  = as_sub;
            end
            OP_AND, OP_XOR, OP_OR: begin
                val               = lg_res;
                result_o          = lg_res;
                acc_we_o          = 1'b1;
                flags_o[FB_HALF]  = lg_hc;
                flags_o[FB_PV]    = even_par(lg_res);
                flags_o[FB_SUB]   = 1'b0;
                flags_o[FB_CARRY] = 1'b0;
            end
            OP_DAA: begin
                val               = da_res;
                result_o          = da_res;
                acc_we_o          = 1'b1;
                flags_o[FB_HALF]  = da_hc;
                flags_o[FB_PV]    = even_par(da_res);
                flags_o[FB_CARRY] = da_co;
            end
            OP_CPL: begin
                result_o         = ~acc_i;
                acc_we_o         = 1'b1;
                flags_o[FB_HALF] = 1'b1;
                flags_o[FB_SUB]  = 1'b1;
            end
            OP_SCF: begin
                flags_o[FB_HALF]  = 1'b0;
                flags_o[FB_SUB]   = 1'b0;
                flags_o[FB_CARRY] = 1'b1;
            end
            OP_CCF: begin
                flags_o[FB_HALF]  = c_in;
                flags_o[FB_SUB]   = 1'b0;
                flags_o[FB_CARRY] = ~c_in;
            end
            default: ;
        endcase
        if (op_i < OP_W'(OP_SCF)) begin
            flags_o[FB_SIGN] = val[DATA_W-1];
            flags_o[FB_ZERO] = (val == '0);
        end
        if (op == OP_CPL) begin
            flags_o[FB_SIGN] = flags_i[FB_SIGN];
            flags_o[FB_ZERO] = flags_i[FB_ZERO];
        end
    end
endmodule

// File: rtl/alu8_core_chk.sv
// Checker for alu8_core: combinational properties between operation code, inputs and outputs.
// Assumes inputs may be unknown before the bench drives them; such values are skipped.
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [DATA_W-1:0] flags_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] result_o,
    input logic              acc_we_o,
    input logic [DATA_W-1:0] flags_o
);
    // Evaluate every property whenever the operation or data changes.
    always_comb begin
        if (!$isunknown({acc_i, opnd_i, flags_i, op_i})) begin
            assert_undef_bits_pass_R1: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]);
            if (op_i == 4'd15)
                assert_hold_idle_R2: assert (!acc_we_o && result_o == acc_i && flags_o == flags_i);
            if (op_i <= 4'd1)
                assert_add_sub_clear_R3: assert (!flags_o[FB_SUB]);
            if (op_i == 4'd2 || op_i == 4'd3 || op_i == 4'd10)
                assert_sub_sets_n_R4: assert (flags_o[FB_SUB]);
            if (op_i == 4'd7)
                assert_cp_no_write_R5: assert (!acc_we_o && result_o == acc_i);
            if (op_i >= 4'd4 && op_i <= 4'd6)
                assert_logic_clear_nc_R6: assert (!flags_o[FB_SUB] && !flags_o[FB_CARRY]
                                                 && flags_o[FB_PV] == ~^result_o);
            if (op_i == 4'd8 || op_i == 4'd9)
                assert_incdec_keep_c_R7: assert (flags_o[FB_CARRY] == flags_i[FB_CARRY]);
            if (op_i == 4'd11)
                assert_cpl_invert_R8: assert (result_o == ~acc_i && flags_o[FB_CARRY] == flags_i[FB_CARRY]);
            if (op_i == 4'd13)
                assert_scf_forces_R9: assert (flags_o[FB_CARRY] && !flags_o[FB_HALF] && !flags_o[FB_SUB]);
            if (op_i == 4'd12)
                assert_daa_keeps_n_R10: assert (flags_o[FB_SUB] == flags_i[FB_SUB]);
            if (acc_we_o && op_i != 4'd11)
                assert_zero_matches_R11: assert (flags_o[FB_ZERO] == (result_o == '0)
                                                 && flags_o[FB_SIGN] == result_o[DATA_W-1]);
            assert_we_decode_R12: assert (acc_we_o == !(op_i == 4'd7 || op_i >= 4'd13));
        end
    end
endmodule

bind alu8_core alu8_core_chk u_chk (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .op_i    (op_i),
    .result_o(result_o),
    .acc_we_o(acc_we_o),
    .flags_o (flags_o)
);

// File: tb/alu8_core_tb.sv
// Directed bench for alu8_core: one task per scenario, expected values worked out by hand.
module alu8_core_tb;
    logic       clk = 1'b0;
    logic [7:0] acc = 8'h00, opnd = 8'h00, fin = 8'h00;
    logic [3:0] op = 4'd15;
    logic [7:0] res, fout;
    logic       we;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    alu8_core u_dut (
        .acc_i(acc), .opnd_i(opnd), .flags_i(fin), .op_i(op),
        .result_o(res), .acc_we_o(we), .flags_o(fout)
    );

    // Status byte from individual bits; bits 5 and 3 come from base.
    function automatic logic [7:0] fb(input logic s, z, h, p, n, c, input logic [7:0] base);
        return {s, z, base[5], h, base[3], p, n, c};
    endfunction

    task automatic drive(input logic [3:0] o, input logic [7:0] a, b, f);
        @(posedge clk);
        op = o; acc = a; opnd = b; fin = f;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic expect_all(input string req, input logic [7:0] r, f, input logic w);
        chk({req, " result"}, res, r);
        chk({req, " flags"}, fout, f);
        chk({req, " write"}, {7'd0, we}, {7'd0, w});
    endtask

    task automatic t_hold();     // R2: code 15 is idle
        drive(4'd15, 8'h33, 8'h44, 8'hFF);
        expect_all("R2 hold", 8'h33, 8'hFF, 1'b0);
    endtask

    task automatic t_add();      // R3, R11
        drive(4'd0, 8'h7F, 8'h01, 8'h00);
        expect_all("R3 add 7F+01", 8'h80, fb(1,0,1,1,0,0,8'h00), 1'b1);
        drive(4'd0, 8'hFF, 8'h01, 8'h00);
        expect_all("R11 add wrap zero", 8'h00, fb(0,1,1,0,0,1,8'h00), 1'b1);
        drive(4'd1, 8'h0F, 8'h00, 8'h01);
        expect_all("R3 adc carry in", 8'h10, fb(0,0,1,0,0,0,8'h00), 1'b1);
    endtask

    task automatic t_sub();      // R4
        drive(4'd2, 8'h80, 8'h01, 8'h00);
        expect_all("R4 sub 80-01", 8'h7F, fb(0,0,1,1,1,0,8'h00), 1'b1);
        drive(4'd3, 8'h00, 8'h00, 8'h01);
        expect_all("R4 sbc borrow", 8'hFF, fb(1,0,1,0,1,1,8'h00), 1'b1);
        drive(4'd10, 8'h80, 8'h00, 8'h00);
        expect_all("R4 neg 80", 8'h80, fb(1,0,0,1,1,1,8'h00), 1'b1);
        drive(4'd10, 8'h00, 8'h00, 8'h00);
        expect_all("R4 neg 00", 8'h00, fb(0,1,0,0,1,0,8'h00), 1'b1);
    endtask

    task automatic t_cp();       // R5
        drive(4'd7, 8'h42, 8'h42, 8'h00);
        expect_all("R5 cp equal", 8'h42, fb(0,1,0,0,1,0,8'h00), 1'b0);
        drive(4'd7, 8'h10, 8'h20, 8'h00);
        expect_all("R5 cp less", 8'h10, fb(1,0,0,0,1,1,8'h00), 1'b0);
    endtask

    task automatic t_logic();    // R6
        drive(4'd4, 8'hF0, 8'h3C, 8'h03);
        expect_all("R6 and", 8'h30, fb(0,0,1,1,0,0,8'h00), 1'b1);
        drive(4'd5, 8'h55, 8'h54, 8'h13);
        expect_all("R6 xor odd", 8'h01, fb(0,0,0,0,0,0,8'h00), 1'b1);
        drive(4'd6, 8'h00, 8'h00, 8'h13);
        expect_all("R6 or zero", 8'h00, fb(0,1,0,1,0,0,8'h00), 1'b1);
    endtask

    task automatic t_incdec();   // R7
        drive(4'd8, 8'h7F, 8'h00, 8'h01);
        expect_all("R7 inc 7F", 8'h80, fb(1,0,1,1,0,1,8'h00), 1'b1);
        drive(4'd9, 8'h80, 8'h00, 8'h00);
        expect_all("R7 dec 80", 8'h7F, fb(0,0,1,1,1,0,8'h00), 1'b1);
        drive(4'd9, 8'h01, 8'h00, 8'h01);
        expect_all("R7 dec to zero", 8'h00, fb(0,1,0,0,1,1,8'h00), 1'b1);
    endtask

    task automatic t_cpl();      // R8
        drive(4'd11, 8'h5A, 8'h00, 8'hC5);
        expect_all("R8 cpl", 8'hA5, 8'hD7, 1'b1);
    endtask

    task automatic t_carry();    // R9
        drive(4'd13, 8'h21, 8'h00, 8'h12);
        expect_all("R9 scf", 8'h21, 8'h01, 1'b0);
        drive(4'd14, 8'h21, 8'h00, 8'hC5);
        expect_all("R9 ccf set", 8'h21, 8'hD4, 1'b0);
        drive(4'd14, 8'h21, 8'h00, 8'h00);
        expect_all("R9 ccf clear", 8'h21, 8'h01, 1'b0);
    endtask

    task automatic t_daa();      // R10
        drive(4'd12, 8'h0A, 8'h00, 8'h00);
        expect_all("R10 daa low", 8'h10, 8'h10, 1'b1);
        drive(4'd12, 8'h9A, 8'h00, 8'h00);
        expect_all("R10 daa both", 8'h00, 8'h55, 1'b1);
        drive(4'd12, 8'h0F, 8'h00, 8'h12);
        expect_all("R10 daa subtract", 8'h09, 8'h06, 1'b1);
    endtask

    task automatic t_passthru(); // R1
        drive(4'd0, 8'h01, 8'h01, 8'h28);
        expect_all("R1 bits 5 3", 8'h02, 8'h28, 1'b1);
    endtask

    // Watchdog: an unfinished run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 idle after start result", res, 8'h00);
        chk("R12 idle write", {7'd0, we}, 8'h00);
        t_hold();
        t_add();
        t_sub();
        t_cp();
        t_logic();
        t_incdec();
        t_cpl();
        t_carry();
        t_daa();
        t_passthru();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule